// File: doc/BRIEF.md
# Serial-In Latched Output Driver

This block turns a slow serial bit stream into twelve parallel output-enable lines for a row of output channels. Bits enter on rising edges of a shift clock and march through a twelve-stage register. The last stage is brought out as a serial output, so several blocks can be chained into a longer row. A strobe passes the register contents into an output latch. A blanking input turns every channel off without disturbing what the latch holds.

All logic runs on one system clock. The shift clock, serial data and strobe are resynchronized through a two-stage synchronizer. A two-state machine, `SCK_LOW` and `SCK_HIGH`, turns each rising edge of the synchronized shift clock into a single one-cycle shift event. Its transitions are *arm* (`SCK_LOW` to `SCK_HIGH` on a high sample, which fires the shift event) and *release* (`SCK_HIGH` to `SCK_LOW` on a low sample). The latch is transparent while the synchronized strobe is high and holds while it is low. When a shift event and a high strobe fall in the same cycle, the latch takes the freshly shifted word. If the strobe is kept high, the outputs ripple while data is shifted, so blanking should then be held high during loading.

Top module: `serial_latch_driver`

## Requirements
- R1: One shift happens per rising edge of `sck`. The serial data bit is captured into stage 0 (`out_en[0]` side), and holding `sck` high produces no further shifts.
- R2: On each shift, every stage i takes the old value of stage i-1. `sdo` always shows stage 11, so after twelve shifts the first bit entered is on `sdo`.
- R3: While `strobe` is high, the latch follows the shift register.
- R4: While `strobe` is low, the latch holds its value even when shifting continues.
- R5: While `blank` is high, all twelve `out_en` bits are 0, whatever the latch holds. Blanking acts combinationally.
- R6: Blanking leaves the latch contents unchanged. Once `blank` returns low, `out_en` shows the latched word again.
- R7: `sdo` depends only on the shift register and is not affected by `blank` or `strobe`.
- R8: When a shift event and a high synchronized strobe occur in the same cycle, the latch takes the newly shifted word in that cycle.
- R9: A synchronous active-high `rst` clears the shift register and the latch to all zeros.
- R10: A rising `sck` becomes a shift on the third rising system-clock edge after it is first sampled (two synchronizer stages, then the shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Shift clock, asynchronous, rising edge shifts |
| sdi | input | 1 | Serial data in |
| strobe | input | 1 | High makes the output latch transparent |
| blank | input | 1 | High forces every output off |
| out_en | output | 12 | Parallel output enables, 1 = channel on |
| sdo | output | 1 | Serial data out, last stage of the register |

## Verification
On every cycle, the assertions check the following. The register moves only on a shift event and then moves by exactly one stage. The edge detector never fires on two cycles in a row. The latch is frozen while the strobe is low and equals the register one cycle after a high strobe. Reset clears both stores. Behaviour that depends on a whole sequence can only be shown by the bench scenarios: twelve-bit words arriving intact on the parallel outputs, the latched word surviving a blanking interval and a burst of new shifts, and the exact three-cycle latency of a shift with a transparent latch.

// File: rtl/sld_pkg.sv
package sld_pkg;
    localparam int CHANNELS    = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SCK_LOW  = 1'b0,
        SCK_HIGH = 1'b1
    } sck_state_t;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/sld_edge_fsm.sv
module sld_edge_fsm
    import sld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck_sync,
    output logic shift_pulse
);
    sck_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCK_LOW:  if (sck_sync)  state_d = SCK_HIGH;
            SCK_HIGH: if (!sck_sync) state_d = SCK_LOW;
            default:                 state_d = SCK_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCK_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        shift_pulse = 1'b0;
        unique case (state_q)
            SCK_LOW:  shift_pulse = sck_sync;
            SCK_HIGH: shift_pulse = 1'b0;
            default:  shift_pulse = 1'b0;
        endcase
    end

    // R1 / R10: a held-high clock yields a single event
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);
endmodule

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_pulse,
    input  logic         din,
    output logic [N-1:0] shift_q,
    output logic [N-1:0] shift_d
);
    always_comb begin
        shift_d = shift_q;
        if (shift_pulse) shift_d = {shift_q[N-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= shift_d;
    end

    a_r1_hold_without_event: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> $stable(shift_q));

    a_r2_one_stage_move: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> shift_q[N-1:1] == $past(shift_q[N-2:0]));

    a_r9_reset_clears_shift: assert property (@(posedge clk)
        rst |=> shift_q == '0);
endmodule

// File: rtl/sld_latch_gate.sv
module sld_latch_gate #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [N-1:0] word_in,
    input  logic         blank,
    output logic [N-1:0] latch_q,
    output logic [N-1:0] out_en
);
    always_ff @(posedge clk) begin
        if (rst)          latch_q <= '0;
        else if (load_en) latch_q <= word_in;
    end

    always_comb begin
        out_en = blank ? '0 : latch_q;
    end

    a_r4_latch_frozen: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(latch_q));

    a_r9_reset_clears_latch: assert property (@(posedge clk)
        rst |=> latch_q == '0);
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
    import sld_pkg::*;
#(
    parameter int N     = CHANNELS,
    parameter int SYNCN = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck,
    input  logic         sdi,
    input  logic         strobe,
    input  logic         blank,
    output logic [N-1:0] out_en,
    output logic         sdo
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              sck_s, sdi_s, stb_s;
    logic              shift_pulse;
    logic [N-1:0]      shift_q, shift_d, latch_q;

    assign raw_in = {strobe, sdi, sck};
    assign sck_s  = synced[0];
    assign sdi_s  = synced[1];
    assign stb_s  = synced[2];

    sld_sync #(.WIDTH(SYNC_W), .STAGES(SYNCN)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_in), .q_sync(synced)
    );

    sld_edge_fsm u_edge (
        .clk(clk), .rst(rst), .sck_sync(sck_s), .shift_pulse(shift_pulse)
    );

    sld_shift_reg #(.N(N)) u_shift (
        .clk(clk), .rst(rst), .shift_pulse(shift_pulse), .din(sdi_s),
        .shift_q(shift_q), .shift_d(shift_d)
    );

    // word_in is the post-shift value so a same-cycle shift is seen (R8)
    sld_latch_gate #(.N(N)) u_latch (
        .clk(clk), .rst(rst), .load_en(stb_s), .word_in(shift_d),
        .blank(blank), .latch_q(latch_q), .out_en(out_en)
    );

    assign sdo = shift_q[N-1];

    // R3 / R8: a transparent latch equals the register one cycle later
    a_r3_latch_tracks: assert property (@(posedge clk) disable iff (rst)
        stb_s |=> latch_q == shift_q);

    // R5: blanking forces every channel off at the port
    a_r5_blank_off: assert property (@(posedge clk) disable iff (rst)
        blank |-> out_en == '0);
endmodule

// File: tb/test_serial_latch_driver.sv
module test_serial_latch_driver;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sck = 1'b0, sdi = 1'b0, strobe = 1'b0, blank = 1'b0;
    logic [N-1:0] out_en;
    logic         sdo;
    int           checks = 0, errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    serial_latch_driver i_serial_latch_driver (
        .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .strobe(strobe),
        .blank(blank), .out_en(out_en), .sdo(sdo)
    );

    // {blank, word}
    localparam logic [N:0] VEC [0:5] = '{
        {1'b0, 12'hA5C}, {1'b0, 12'h001}, {1'b1, 12'hFFF},
        {1'b0, 12'h800}, {1'b0, 12'h3C6}, {1'b1, 12'h5A5}
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdi = b; sck = 1'b1;
        wait_n(4);
        sck = 1'b0;
        wait_n(4);
    endtask

    task automatic shift_word(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1; wait_n(4);
        strobe = 1'b0; wait_n(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        chk("R9 reset out_en", out_en, '0);
        chk("R9 reset sdo", {11'b0, sdo}, '0);

        // table walk: R2 word arrival, R4 hold, R5 blank, R7 sdo
        for (int v = 0; v < 6; v++) begin
            blank = VEC[v][N];
            shift_word(VEC[v][N-1:0]);
            pulse_strobe();
            chk("R2/R5 table out_en", out_en, VEC[v][N] ? '0 : VEC[v][N-1:0]);
            chk("R7 table sdo", {11'b0, sdo}, {11'b0, VEC[v][N-1]});
        end

        // R6: latch survives blank and new shifts; R4 hold without strobe
        blank = 1'b0;
        shift_word(12'h6B1); pulse_strobe();
        blank = 1'b1;
        shift_word(12'h0F0);
        chk("R5 blank during load", out_en, '0);
        chk("R7 sdo under blank", {11'b0, sdo}, 12'h000);
        blank = 1'b0; wait_n(1);
        chk("R6 restored after blank", out_en, 12'h6B1);
        chk("R4 hold while shifting", out_en, 12'h6B1);

        // R1: held-high sck produces one shift only
        rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
        chk("R9 mid-run reset", out_en, '0);
        strobe = 1'b1; wait_n(4);
        sdi = 1'b1; sck = 1'b1; wait_n(20);
        chk("R1 single shift", out_en, 12'h001);
        sck = 1'b0; wait_n(4);
        shift_bit(1'b0);
        chk("R3 transparent ripple", out_en, 12'h002);

        // R10 / R8: exact latency with transparent latch
        sdi = 1'b1; sck = 1'b1;
        wait_n(2);
        chk("R10 no shift yet", out_en, 12'h002);
        wait_n(1);
        chk("R8/R10 same-cycle latch", out_en, 12'h005);
        sck = 1'b0; wait_n(4);
        strobe = 1'b0; wait_n(4);

        // R2: first bit of a word reaches sdo after 12 shifts
        shift_word(12'h800);
        chk("R2 sdo after 12 shifts", {11'b0, sdo}, 12'h001);
        chk("R4 latch held", out_en, 12'h005);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule